// File: doc/BRIEF.md
# Bridge Secondary Status Error Logger

This block holds the sticky error flags in the secondary status word of a PCI Express root port. The word is 16 bits wide and sits at byte offset 0x1E of configuration space. The port's transaction logic sends the block single-cycle event strobes, each with qualifiers:

- a received TLP, with its poison flag;
- a received error message, with its severity code and a marker for messages the port generated itself;
- a received completion, with its status code;
- a transmitted completion, with its status code;
- a Type0 configuration request that the port master-aborted, with its device number.

Each kind of event feeds one flag through its own qualified condition. A flag stays set until software writes a one to it.

Software uses a plain register port. A read returns the word addressed in the same cycle. A write takes effect on the next clock edge. Only the upper byte lane can clear flags, and writing zero leaves a flag as it is. The DEVSEL timing field and the low status bits are constant zero. The I/O limit capability bits in the byte at 0x1D also read as zero, which means only 16-bit I/O addressing is supported. If a flag is set and cleared in the same cycle, the set wins so that no event is lost.

Top module: `sec_err_status_reg`

## Requirements
- R1: After reset is asserted, the status word at offset 0x1E reads 0x0000.
- R2: A received TLP strobe with the poison flag high sets bit 15, whatever the value of the parity-response enable input. A TLP that is not poisoned leaves bit 15 unchanged.
- R3: An external received error message sets bit 14 when its code is 2'b01 (non-fatal) or 2'b11 (fatal). An internally generated message, code 2'b00 (correctable) and code 2'b10 leave bit 14 unchanged.
- R4: Bit 13 sets when a received completion has status 3'b001 (unsupported request). It also sets when a master-aborted Type0 configuration request has a nonzero device number. Device number 0 leaves bit 13 unchanged.
- R5: A received completion with status 3'b100 (completer abort) sets bit 12.
- R6: A transmitted completion with status 3'b100 sets bit 11, whether or not it is flagged as a forwarded peer-to-peer completion. Any other transmitted status leaves bit 11 unchanged.
- R7: Bits 15:11 are write-one-to-clear on a write to offset 0x1E with the upper byte enable (regWrBe[1]) high. A data bit of 0, or the upper byte enable low, leaves a flag unchanged.
- R8: When a set event and a clearing write hit the same bit in the same cycle, that bit ends up set.
- R9: Bits 10:0 of the status word always read 0, and writes to them are ignored. A read of any other address, including the word at 0x1C that holds the 0x1D I/O limit byte, returns 0.
- R10: regRdData follows regAddr and the flag state in the same cycle. A write or event shows on regRdData only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bridgeParityEn | input | 1 | Parity error response enable from bridge control (does not affect bit 15) |
| rxTlpValid | input | 1 | Received TLP strobe |
| rxTlpPoisoned | input | 1 | Poison flag of the received TLP |
| rxErrMsgValid | input | 1 | Received error message strobe |
| rxErrMsgCode | input | 2 | 00 correctable, 01 non-fatal, 11 fatal, 10 unused |
| rxErrMsgInternal | input | 1 | Message was generated inside the port |
| rxCplValid | input | 1 | Received completion strobe |
| rxCplStatus | input | 3 | Completion status (001 UR, 100 CA) |
| txCplValid | input | 1 | Transmitted completion strobe |
| txCplStatus | input | 3 | Completion status of transmitted completion |
| txCplForwarded | input | 1 | Completion forwarded peer-to-peer |
| cfgAbortValid | input | 1 | Type0 configuration request master-aborted |
| cfgDevNum | input | 5 | Device number of that request |
| regAddr | input | 12 | Byte address of the 16-bit word accessed |
| regWrEn | input | 1 | Write strobe |
| regWrBe | input | 2 | Byte enables for the write |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr |

## Verification
Two functions can fall in one cycle: a flag's event and a software write of one to the same bit. The bench provokes this in directed steps, where a poison strobe and a clearing write of 0xF800 share a clock. It also provokes it in a long random phase, where events and clearing writes overlap freely. A behavioural model applies the rule that the set wins, and the read value is compared on every clock. This shows whether a flag is lost or wrongly cleared, both when the collision happens and in every later cycle.

// File: rtl/sec_err_pkg.sv
package sec_err_pkg;

  localparam int STICKY_N   = 5;
  localparam int STICKY_LSB = 11;
  localparam int WORD_W     = 16;

  // Index of each flag inside the sticky vector (bit STICKY_LSB + index)
  localparam int IDX_SIG_TABORT = 0;
  localparam int IDX_RX_TABORT  = 1;
  localparam int IDX_RX_MABORT  = 2;
  localparam int IDX_RX_SYSERR  = 3;
  localparam int IDX_PARITY     = 4;

  localparam logic [2:0] CPL_UR = 3'b001;
  localparam logic [2:0] CPL_CA = 3'b100;

  localparam logic [1:0] MSG_NONFATAL = 2'b01;
  localparam logic [1:0] MSG_FATAL    = 2'b11;

  typedef struct packed {
    logic [STICKY_N-1:0] setVec;
    logic [STICKY_N-1:0] clrVec;
    logic                rdHit;
  } statusCtrl_t;

endpackage

// File: rtl/sec_err_event_ctrl.sv
module sec_err_event_ctrl
  import sec_err_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEV_W = 5,
  parameter logic [ADDR_W-1:0] STATUS_OFFSET = 'h1E
) (
  input  logic               bridgeParityEn,
  input  logic               rxTlpValid,
  input  logic               rxTlpPoisoned,
  input  logic               rxErrMsgValid,
  input  logic [1:0]         rxErrMsgCode,
  input  logic               rxErrMsgInternal,
  input  logic               rxCplValid,
  input  logic [2:0]         rxCplStatus,
  input  logic               txCplValid,
  input  logic [2:0]         txCplStatus,
  input  logic               txCplForwarded,
  input  logic               cfgAbortValid,
  input  logic [DEV_W-1:0]   cfgDevNum,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [1:0]         regWrBe,
  input  logic [WORD_W-1:0]  regWrData,
  output statusCtrl_t        ctrl
);

  logic unusedInputs;
  logic msgIsSevere;
  logic cfgMasterAbort;
  logic wrUpperHit;

  // The parity enable and forwarded marker must not qualify any flag
  assign unusedInputs = &{1'b0, bridgeParityEn, txCplForwarded, regWrData[STICKY_LSB-1:0], regWrBe[0]};

  assign msgIsSevere    = (rxErrMsgCode == MSG_NONFATAL) || (rxErrMsgCode == MSG_FATAL);
  assign cfgMasterAbort = cfgAbortValid && (cfgDevNum != '0);
  assign wrUpperHit     = regWrEn && (regAddr == STATUS_OFFSET) && regWrBe[1];

  always_comb begin
    ctrl = '0;
    ctrl.rdHit = (regAddr == STATUS_OFFSET);
    ctrl.setVec[IDX_PARITY]     = rxTlpValid && rxTlpPoisoned;
    ctrl.setVec[IDX_RX_SYSERR]  = rxErrMsgValid && !rxErrMsgInternal && msgIsSevere;
    ctrl.setVec[IDX_RX_MABORT]  = (rxCplValid && (rxCplStatus == CPL_UR)) || cfgMasterAbort;
    ctrl.setVec[IDX_RX_TABORT]  = rxCplValid && (rxCplStatus == CPL_CA);
    ctrl.setVec[IDX_SIG_TABORT] = txCplValid && (txCplStatus == CPL_CA);
    ctrl.clrVec = wrUpperHit ? regWrData[STICKY_LSB +: STICKY_N] : '0;
  end

endmodule

// File: rtl/sec_err_status_dp.sv
module sec_err_status_dp
  import sec_err_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  statusCtrl_t       ctrl,
  output logic [WORD_W-1:0] statusWord,
  output logic [WORD_W-1:0] regRdData
);

  localparam int LOW_ZERO_W = STICKY_LSB;

  logic [STICKY_N-1:0] stickyQ;

  genvar gi;
  generate
    for (gi = 0; gi < STICKY_N; gi++) begin : g_flag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stickyQ[gi] <= 1'b0;
        end else if (ctrl.setVec[gi]) begin
          stickyQ[gi] <= 1'b1;
        end else if (ctrl.clrVec[gi]) begin
          stickyQ[gi] <= 1'b0;
        end
      end
    end
  endgenerate

  assign statusWord = {stickyQ, {LOW_ZERO_W{1'b0}}};
  assign regRdData  = ctrl.rdHit ? statusWord : '0;

endmodule

// File: rtl/sec_err_status_reg.sv
module sec_err_status_reg
  import sec_err_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEV_W = 5,
  parameter logic [ADDR_W-1:0] STATUS_OFFSET = 'h1E
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bridgeParityEn,
  input  logic               rxTlpValid,
  input  logic               rxTlpPoisoned,
  input  logic               rxErrMsgValid,
  input  logic [1:0]         rxErrMsgCode,
  input  logic               rxErrMsgInternal,
  input  logic               rxCplValid,
  input  logic [2:0]         rxCplStatus,
  input  logic               txCplValid,
  input  logic [2:0]         txCplStatus,
  input  logic               txCplForwarded,
  input  logic               cfgAbortValid,
  input  logic [DEV_W-1:0]   cfgDevNum,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [1:0]         regWrBe,
  input  logic [WORD_W-1:0]  regWrData,
  output logic [WORD_W-1:0]  regRdData
);

  statusCtrl_t       ctrl;
  logic [WORD_W-1:0] statusWord;

  sec_err_event_ctrl #(
    .ADDR_W(ADDR_W), .DEV_W(DEV_W), .STATUS_OFFSET(STATUS_OFFSET)
  ) u_ctrl (
    .bridgeParityEn(bridgeParityEn), .rxTlpValid(rxTlpValid), .rxTlpPoisoned(rxTlpPoisoned),
    .rxErrMsgValid(rxErrMsgValid), .rxErrMsgCode(rxErrMsgCode), .rxErrMsgInternal(rxErrMsgInternal),
    .rxCplValid(rxCplValid), .rxCplStatus(rxCplStatus), .txCplValid(txCplValid),
    .txCplStatus(txCplStatus), .txCplForwarded(txCplForwarded), .cfgAbortValid(cfgAbortValid),
    .cfgDevNum(cfgDevNum), .regAddr(regAddr), .regWrEn(regWrEn), .regWrBe(regWrBe),
    .regWrData(regWrData), .ctrl(ctrl)
  );

  sec_err_status_dp u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .statusWord(statusWord), .regRdData(regRdData)
  );

endmodule

// File: rtl/sec_err_status_chk.sv
module sec_err_status_chk #(
  parameter int ADDR_W = 12,
  parameter int DEV_W = 5,
  parameter logic [ADDR_W-1:0] STATUS_OFFSET = 'h1E
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxTlpValid,
  input logic              rxTlpPoisoned,
  input logic              rxErrMsgValid,
  input logic [1:0]        rxErrMsgCode,
  input logic              rxErrMsgInternal,
  input logic              txCplValid,
  input logic [2:0]        txCplStatus,
  input logic              cfgAbortValid,
  input logic [DEV_W-1:0]  cfgDevNum,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [15:0]       statusWord,
  input logic [15:0]       regRdData
);

  AST_POISON_SETS: assert property (@(posedge clk) disable iff (!rstN)
    rxTlpValid && rxTlpPoisoned |=> statusWord[15]); // R2

  AST_FATAL_MSG_SETS: assert property (@(posedge clk) disable iff (!rstN)
    rxErrMsgValid && !rxErrMsgInternal && (rxErrMsgCode == 2'b11) |=> statusWord[14]); // R3

  AST_CFG_MABORT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    cfgAbortValid && (cfgDevNum != '0) |=> statusWord[13]); // R4

  AST_TX_CA_SETS: assert property (@(posedge clk) disable iff (!rstN)
    txCplValid && (txCplStatus == 3'b100) |=> statusWord[11]); // R6

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn && statusWord[15] |=> statusWord[15]); // R7

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[10:0] == 11'd0); // R9

  AST_READ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == STATUS_OFFSET) |-> (regRdData == statusWord)); // R10

  AST_OTHER_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != STATUS_OFFSET) |-> (regRdData == 16'd0)); // R9

endmodule

bind sec_err_status_reg sec_err_status_chk #(
  .ADDR_W(ADDR_W), .DEV_W(DEV_W), .STATUS_OFFSET(STATUS_OFFSET)
) u_chk (.*);

// File: tb/test_sec_err_status_reg.sv
`timescale 1ns/1ps
module test_sec_err_status_reg;

  localparam real PERIOD = 8.0;
  localparam logic [11:0] OFF = 12'h01E;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bridgeParityEn, rxTlpValid, rxTlpPoisoned, rxErrMsgValid, rxErrMsgInternal;
  logic [1:0] rxErrMsgCode;
  logic rxCplValid, txCplValid, txCplForwarded, cfgAbortValid, regWrEn;
  logic [2:0] rxCplStatus, txCplStatus;
  logic [4:0] cfgDevNum;
  logic [11:0] regAddr;
  logic [1:0] regWrBe;
  logic [15:0] regWrData, regRdData;

  int compared = 0;
  int mismatched = 0;
  logic [15:0] model = 16'h0;

  always #(PERIOD/2) clk = ~clk;

  sec_err_status_reg i_sec_err_status_reg (.*);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    bridgeParityEn = 0; rxTlpValid = 0; rxTlpPoisoned = 0; rxErrMsgValid = 0;
    rxErrMsgCode = 0; rxErrMsgInternal = 0; rxCplValid = 0; rxCplStatus = 0;
    txCplValid = 0; txCplStatus = 0; txCplForwarded = 0; cfgAbortValid = 0;
    cfgDevNum = 0; regAddr = OFF; regWrEn = 0; regWrBe = 0; regWrData = 0;
  endtask

  function automatic logic [15:0] nextModel();
    logic [15:0] sets = 16'h0;
    logic [15:0] clr = 16'h0;
    if (rxTlpValid && rxTlpPoisoned) sets[15] = 1;
    if (rxErrMsgValid && !rxErrMsgInternal && (rxErrMsgCode == 2'b01 || rxErrMsgCode == 2'b11)) sets[14] = 1;
    if ((rxCplValid && rxCplStatus == 3'b001) || (cfgAbortValid && cfgDevNum != 0)) sets[13] = 1;
    if (rxCplValid && rxCplStatus == 3'b100) sets[12] = 1;
    if (txCplValid && txCplStatus == 3'b100) sets[11] = 1;
    if (regWrEn && regAddr == OFF && regWrBe[1]) clr = regWrData & 16'hF800;
    return ((model & ~clr) | sets) & 16'hF800;
  endfunction

  // Called with inputs already driven, between edges
  task automatic tick(input string tag);
    logic [15:0] nxt;
    #1;
    check({tag, " R10 pre-edge"}, regRdData, (regAddr == OFF) ? model : 16'h0);
    nxt = nextModel();
    @(posedge clk);
    model = nxt;
    @(negedge clk);
    check(tag, regRdData, (regAddr == OFF) ? model : 16'h0);
    idle();
  endtask

  task automatic clearAll();
    regWrEn = 1; regWrBe = 2'b11; regWrData = 16'hFFFF;
    tick("clear-all R7");
  endtask

  initial begin : watchdog
    #(PERIOD * 200000);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    check("R1 in reset", regRdData, 16'h0);
    rstN = 1;
    @(negedge clk);
    check("R1 after reset", regRdData, 16'h0);

    rxTlpValid = 1; rxTlpPoisoned = 0; tick("R2 clean TLP");
    rxTlpValid = 0; rxTlpPoisoned = 1; tick("R2 poison without strobe");
    rxTlpValid = 1; rxTlpPoisoned = 1; bridgeParityEn = 0; tick("R2 poison enable low");
    clearAll();
    rxTlpValid = 1; rxTlpPoisoned = 1; bridgeParityEn = 1; tick("R2 poison enable high");
    clearAll();

    rxErrMsgValid = 1; rxErrMsgCode = 2'b11; rxErrMsgInternal = 1; tick("R3 internal fatal");
    rxErrMsgValid = 1; rxErrMsgCode = 2'b00; tick("R3 correctable");
    rxErrMsgValid = 1; rxErrMsgCode = 2'b10; tick("R3 code 10");
    rxErrMsgValid = 1; rxErrMsgCode = 2'b01; tick("R3 nonfatal");
    clearAll();
    rxErrMsgValid = 1; rxErrMsgCode = 2'b11; tick("R3 fatal");
    clearAll();

    rxCplValid = 1; rxCplStatus = 3'b001; tick("R4 UR completion");
    clearAll();
    cfgAbortValid = 1; cfgDevNum = 0; tick("R4 cfg dev 0");
    cfgAbortValid = 1; cfgDevNum = 5'd31; tick("R4 cfg dev 31");
    clearAll();

    rxCplValid = 1; rxCplStatus = 3'b100; tick("R5 CA completion");
    rxCplValid = 1; rxCplStatus = 3'b000; tick("R5 SC completion");
    clearAll();

    txCplValid = 1; txCplStatus = 3'b001; tick("R6 tx UR");
    txCplValid = 1; txCplStatus = 3'b100; txCplForwarded = 1; tick("R6 tx CA forwarded");
    clearAll();
    txCplValid = 1; txCplStatus = 3'b100; txCplForwarded = 0; tick("R6 tx CA local");

    rxTlpValid = 1; rxTlpPoisoned = 1; rxCplValid = 1; rxCplStatus = 3'b100; tick("R7 setup");
    regWrEn = 1; regWrBe = 2'b11; regWrData = 16'h0000; tick("R7 write zeros");
    regWrEn = 1; regWrBe = 2'b01; regWrData = 16'hFFFF; tick("R7 lower lane only");
    regWrEn = 1; regWrBe = 2'b10; regWrData = 16'hFFFF; regAddr = 12'h01C; tick("R7 wrong address");
    regWrEn = 1; regWrBe = 2'b10; regWrData = 16'h0800; tick("R7 clear bit11 only");

    rxTlpValid = 1; rxTlpPoisoned = 1; regWrEn = 1; regWrBe = 2'b11; regWrData = 16'hF800;
    tick("R8 set and clear collide");

    regWrEn = 1; regWrBe = 2'b11; regWrData = 16'h07FF; tick("R9 write RO bits");
    regAddr = 12'h01C; tick("R9 read 0x1C word");
    regAddr = 12'h000; tick("R9 read offset 0");

    for (int i = 0; i < 400; i++) begin
      bridgeParityEn = 1'($urandom);
      rxTlpValid = 1'($urandom); rxTlpPoisoned = 1'($urandom);
      rxErrMsgValid = 1'($urandom); rxErrMsgCode = 2'($urandom); rxErrMsgInternal = 1'($urandom);
      rxCplValid = ($urandom % 3) == 0; rxCplStatus = 3'($urandom);
      txCplValid = ($urandom % 3) == 0; txCplStatus = 3'($urandom); txCplForwarded = 1'($urandom);
      cfgAbortValid = ($urandom % 4) == 0; cfgDevNum = 5'($urandom % 3);
      regAddr = (($urandom % 8) == 0) ? 12'h01C : OFF;
      regWrEn = 1'($urandom); regWrBe = 2'($urandom); regWrData = 16'($urandom);
      tick("RAND R8");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule